// File: doc/BRIEF.md
# 16-bit Timer/Counter with Mode-Selected TOP

This block is a 16-bit up-counter with a small register port, three output-compare channels and an edge-triggered capture unit. The counter advances once per clock in which the prescaled enable `cnt_en` is high. A 4-bit mode field selects where the counter turns around (its TOP). TOP can be the full 16-bit range, one of three fixed 8/9/10-bit limits, the compare-A register, or the capture register. When compare A supplies TOP, the value that software writes is held in a buffer. That buffer is copied into the working register only at the wrap, so TOP can be retuned while the timer runs.

Each compare channel sets its own match flag. In fast-PWM modes the channel output is set at BOTTOM and cleared on a match. In normal mode the output toggles on a match. Writing a force strobe applies the match action to the output at once, without setting a flag. The capture unit copies the counter into the capture register on a chosen edge of either the capture pin or the comparator input. An optional four-sample filter can reject short spikes on that input. Interrupt requests combine the flags with a mask. Flags are cleared by writing ones to them. All inputs are taken as synchronous to `clk`.

Top module: `tmr16`

## Requirements
- R1: After reset the counter, all compare and capture registers, the flags, the mask, the compare outputs and `irq` are zero.
- R2: With `cnt_en` high the counter increments once per clock. In mode 0 (and in the unused modes 6 to 15), TOP is 0xFFFF. On the tick at TOP the counter goes to 0x0000 and sets flag bit 0 (overflow).
- R3: Modes 1, 2 and 3 are fast-PWM modes with TOP fixed at 0x00FF, 0x01FF and 0x03FF. In mode 2 the value 0x00FF is passed through rather than wrapped.
- R4: Mode 4 is fast PWM with TOP equal to compare A. Writes to address 2 go to a buffer that becomes the active TOP at the next wrap. In every other mode they take effect on the next clock. In mode 4, output A (`oc_out[0]`) is held at 0.
- R5: Mode 5 is fast PWM with TOP equal to the capture register (address 5, writable). Channel A drives a PWM waveform in this mode.
- R6: A tick on which the counter equals a channel's active compare value sets flag bit 1, 2 or 3 (channels A, B, C). `irq` is high while any flag bit is set whose mask bit (address 7, bits 4:0) is set. Writing a one to a bit of address 6 clears that flag.
- R7: In modes 1 to 5 a channel output goes to 1 on the wrap tick and to 0 on a match tick, and the wrap wins when both happen on the same tick. In the other modes a match toggles the output.
- R8: Writing a one to bit 8, 9 or 10 of address 7 applies the match action to output A, B or C. It sets no flag and leaves the counter unchanged.
- R9: Control bit 4 selects the capture source (0 = capture pin, 1 = comparator) and bit 5 selects the edge (1 = rising, 0 = falling). On the selected edge, the capture register takes the counter value and flag bit 4 is set. Edges of the other source, and edges of the other polarity, are ignored.
- R10: When control bit 6 is set, an input level is accepted only after four consecutive equal samples. A pulse shorter than four clocks causes no capture.
- R11: While `cnt_en` is low, the counter holds its value. A write to address 1 loads the counter, and that write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 ctrl, 1 count, 2 cmp A, 3 cmp B, 4 cmp C, 5 capture, 6 flags, 7 mask/force) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| cap_pin | input | 1 | Capture pin |
| cmp_in | input | 1 | Comparator output |
| oc_out | output | 3 | Compare outputs A, B, C |
| flags | output | 5 | Overflow, match A/B/C, capture |
| irq | output | 1 | Masked interrupt request |

## Verification
Suppose the TOP selection or the compare-A buffer is wrong. The count sequence at `rd_data` then passes the expected wrap point, or wraps too early, and this is visible on the first tick at TOP. A wrong match or force path shows up on `oc_out` or `flags` one clock after the tick or strobe. A fault in the capture path or the filter leaves a stale or wrong value in the capture register, and it can be read back a few clocks after the input pulse ends.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [3:0] MODE_NORMAL  = 4'd0;
  localparam logic [3:0] MODE_FIX8    = 4'd1;
  localparam logic [3:0] MODE_FIX10   = 4'd3;
  localparam logic [3:0] MODE_TOP_CMP = 4'd4;
  localparam logic [3:0] MODE_TOP_CAP = 4'd5;

  // Fixed limit for modes 1..3: 2^(7+mode)-1
  function automatic int fixed_limit(logic [3:0] m);
    return (1 << (7 + int'(m))) - 1;
  endfunction

  function automatic logic mode_is_pwm(logic [3:0] m);
    return (m >= MODE_FIX8) && (m <= MODE_TOP_CAP);
  endfunction

  function automatic logic mode_is_fixed(logic [3:0] m);
    return (m >= MODE_FIX8) && (m <= MODE_FIX10);
  endfunction
endpackage

// File: rtl/tmr16_topsel.sv
module tmr16_topsel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode,
  input  logic         wr_cmpa,
  input  logic [W-1:0] wdata,
  input  logic         wrap_ev,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] cmpa_act,
  output logic [W-1:0] cmpa_buf,
  output logic [W-1:0] top_val
);
  import tmr16_pkg::*;

  logic buf_mode;
  assign buf_mode = (mode == MODE_TOP_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpa_buf <= '0;
      cmpa_act <= '0;
    end else begin
      if (wr_cmpa) cmpa_buf <= wdata;
      if (!buf_mode)    cmpa_act <= wr_cmpa ? wdata : cmpa_buf;
      else if (wrap_ev) cmpa_act <= cmpa_buf;
    end
  end

  always_comb begin
    if (mode_is_fixed(mode))       top_val = W'(fixed_limit(mode));
    else if (mode == MODE_TOP_CMP) top_val = cmpa_act;
    else if (mode == MODE_TOP_CAP) top_val = cap_val;
    else                           top_val = '1;
  end

  // R4: buffered TOP changes only at the wrap
  p_dbuf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !wrap_ev) |=> $stable(cmpa_act));
endmodule

// File: rtl/tmr16_cmpch.sv
module tmr16_cmpch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         tick,
  input  logic         wrap_ev,
  input  logic [W-1:0] cmp_val,
  input  logic         pwm,
  input  logic         hold_low,
  input  logic         force_s,
  input  logic         flag_clr,
  output logic         match,
  output logic         flag_o,
  output logic         out_o
);
  assign match = tick && (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      out_o  <= 1'b0;
    end else begin
      if (match)         flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
      if (hold_low)                  out_o <= 1'b0;
      else if (pwm) begin
        if (wrap_ev)                 out_o <= 1'b1;
        else if (match || force_s)   out_o <= 1'b0;
      end else if (match || force_s) out_o <= ~out_o;
    end
  end

  // R8: force never raises the flag
  p_force_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_s && !match && !flag_o) |=> !flag_o);
  // R7: PWM output goes high after a wrap tick
  p_pwm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !hold_low && wrap_ev) |=> out_o);
  // R4: held channel stays low
  p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_low |=> !out_o);
endmodule

// File: rtl/tmr16_capt.sv
module tmr16_capt #(
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic cmp,
  input  logic src_sel,
  input  logic rise_sel,
  input  logic filt_en,
  output logic cap_ev
);
  logic              raw, raw_q, filt, lvl, lvl_q;
  logic [FILT_N-1:0] smp;

  assign raw = src_sel ? cmp : pin;
  assign lvl = filt_en ? filt : raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp   <= '0;
      raw_q <= 1'b0;
      filt  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      smp   <= {smp[FILT_N-2:0], raw};
      raw_q <= raw;
      if (&smp)       filt <= 1'b1;
      else if (~|smp) filt <= 1'b0;
      lvl_q <= lvl;
    end
  end

  assign cap_ev = rise_sel ? (lvl && !lvl_q) : (!lvl && lvl_q);

  // R10: filtered level moves only after a full run of equal samples
  p_filter_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&smp) && !(~|smp)) |=> $stable(filt));
endmodule

// File: rtl/tmr16.sv
module tmr16 #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [15:0]  wr_data,
  output logic [15:0]  rd_data,
  input  logic         cap_pin,
  input  logic         cmp_in,
  output logic [2:0]   oc_out,
  output logic [4:0]   flags,
  output logic         irq
);
  import tmr16_pkg::*;

  localparam int NFLAG = NCH + 2;

  logic [6:0]       ctrl;
  logic [W-1:0]     cnt, icr, cmpa_act, cmpa_buf, top_val;
  logic [W-1:0]     cmp_val [NCH];
  logic [W-1:0]     cmp_reg [NCH];
  logic [NFLAG-1:0] mask;
  logic             ovf_f, cap_f, cap_ev, at_wrap, wrap_ev, cnt_wr;
  logic [NCH-1:0]   ch_flag, ch_out, ch_match;
  logic [3:0]       mode;

  assign mode    = ctrl[3:0];
  assign cnt_wr  = wr_en && (addr == 3'd1);
  assign at_wrap = (cnt == top_val) || (cnt == '1);
  assign wrap_ev = cnt_en && at_wrap && !cnt_wr;

  tmr16_topsel #(.W(W)) u_top (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .wr_cmpa(wr_en && addr == 3'd2), .wdata(wr_data),
    .wrap_ev(wrap_ev), .cap_val(icr),
    .cmpa_act(cmpa_act), .cmpa_buf(cmpa_buf), .top_val(top_val));

  tmr16_capt #(.FILT_N(4)) u_capt (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .cmp(cmp_in),
    .src_sel(ctrl[4]), .rise_sel(ctrl[5]), .filt_en(ctrl[6]),
    .cap_ev(cap_ev));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; cnt <= '0; icr <= '0; mask <= '0;
      ovf_f <= 1'b0; cap_f <= 1'b0;
      cmp_reg[1] <= '0; cmp_reg[2] <= '0;
    end else begin
      if (wr_en && addr == 3'd0) ctrl <= wr_data[6:0];
      if (wr_en && addr == 3'd3) cmp_reg[1] <= wr_data;
      if (wr_en && addr == 3'd4) cmp_reg[2] <= wr_data;
      if (wr_en && addr == 3'd7) mask <= wr_data[NFLAG-1:0];
      if (cnt_wr)      cnt <= wr_data;
      else if (cnt_en) cnt <= at_wrap ? '0 : cnt + 1'b1;
      if (cap_ev)                     icr <= cnt;
      else if (wr_en && addr == 3'd5) icr <= wr_data;
      if (wrap_ev) ovf_f <= 1'b1;
      else if (wr_en && addr == 3'd6 && wr_data[0]) ovf_f <= 1'b0;
      if (cap_ev) cap_f <= 1'b1;
      else if (wr_en && addr == 3'd6 && wr_data[NFLAG-1]) cap_f <= 1'b0;
    end
  end

  assign cmp_reg[0] = cmpa_buf;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_a
      assign cmp_val[i] = cmpa_act;
    end else begin : g_bc
      assign cmp_val[i] = cmp_reg[i];
    end
    tmr16_cmpch #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .tick(cnt_en && !cnt_wr),
      .wrap_ev(wrap_ev), .cmp_val(cmp_val[i]), .pwm(mode_is_pwm(mode)),
      .hold_low(i == 0 && mode == MODE_TOP_CMP),
      .force_s(wr_en && addr == 3'd7 && wr_data[8+i]),
      .flag_clr(wr_en && addr == 3'd6 && wr_data[1+i]),
      .match(ch_match[i]), .flag_o(ch_flag[i]), .out_o(ch_out[i]));
  end

  assign flags  = {cap_f, ch_flag, ovf_f};
  assign oc_out = ch_out;
  assign irq    = |(flags & mask);

  always_comb begin
    case (addr)
      3'd0:    rd_data = 16'(ctrl);
      3'd1:    rd_data = cnt;
      3'd2:    rd_data = cmpa_buf;
      3'd3:    rd_data = cmp_reg[1];
      3'd4:    rd_data = cmp_reg[2];
      3'd5:    rd_data = icr;
      3'd6:    rd_data = 16'(flags);
      default: rd_data = 16'(mask);
    endcase
  end

  // R2: tick at TOP returns the counter to BOTTOM
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (cnt == '0));
  // R11: no enable and no write keeps the count
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_wr) |=> $stable(cnt));
  // R9: capture latches the counter of the event cycle
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (icr == $past(cnt)) && cap_f);
  // R6: match on a channel raises its flag
  p_match_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ch_match[1] |=> flags[2]);
endmodule

// File: tb/tmr16_tb.sv
`timescale 1ns/1ps
module tmr16_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic        cap_pin = 1'b0, cmp_in = 1'b0;
  logic [2:0]  oc_out;
  logic [4:0]  flags;
  logic        irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  tmr16 dut_i (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cap_pin(cap_pin),
    .cmp_in(cmp_in), .oc_out(oc_out), .flags(flags), .irq(irq));

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic tick(int n);
    @(negedge clk); cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(3'd1, v); chk("R1 count", v, 16'h0);
    rd(3'd5, v); chk("R1 capture", v, 16'h0);
    chk("R1 flags", 16'(flags), 16'h0);
    chk("R1 outputs", 16'(oc_out), 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_normal;
    logic [15:0] v;
    wr(3'd0, 16'h0000); wr(3'd1, 16'hFFFD); wr(3'd6, 16'h001F);
    tick(2); rd(3'd1, v); chk("R2 count to MAX", v, 16'hFFFF);
    chk("R2 no early ovf", 16'(flags[0]), 16'h0);
    tick(1); rd(3'd1, v); chk("R2 wrap to BOTTOM", v, 16'h0000);
    chk("R2 ovf flag", 16'(flags[0]), 16'h1);
    wait_clk(3); rd(3'd1, v); chk("R11 hold when disabled", v, 16'h0000);
  endtask

  task automatic t_fixed;
    logic [15:0] v;
    wr(3'd0, 16'h0001); wr(3'd1, 16'h00FE);
    tick(2); rd(3'd1, v); chk("R3 8-bit wrap", v, 16'h0000);
    wr(3'd0, 16'h0002); wr(3'd1, 16'h00FF);
    tick(1); rd(3'd1, v); chk("R3 9-bit passes 0xFF", v, 16'h0100);
    wr(3'd1, 16'h01FF); tick(1); rd(3'd1, v); chk("R3 9-bit wrap", v, 16'h0000);
    wr(3'd0, 16'h0003); wr(3'd1, 16'h03FE);
    tick(1); rd(3'd1, v); chk("R3 10-bit top", v, 16'h03FF);
    tick(1); rd(3'd1, v); chk("R3 10-bit wrap", v, 16'h0000);
  endtask

  task automatic t_topa;
    logic [15:0] v;
    wr(3'd0, 16'h0000); wr(3'd2, 16'h0010);
    wr(3'd0, 16'h0004); wr(3'd2, 16'h0020); wr(3'd1, 16'h000E);
    tick(2); rd(3'd1, v); chk("R4 reaches old TOP", v, 16'h0010);
    tick(1); rd(3'd1, v); chk("R4 wraps at old TOP", v, 16'h0000);
    chk("R4 channel A held low", 16'(oc_out[0]), 16'h0);
    wr(3'd1, 16'h001F); tick(1); rd(3'd1, v); chk("R4 new TOP reached", v, 16'h0020);
    tick(1); rd(3'd1, v); chk("R4 wraps at new TOP", v, 16'h0000);
    chk("R4 channel A still low", 16'(oc_out[0]), 16'h0);
  endtask

  task automatic t_topcap;
    logic [15:0] v;
    wr(3'd0, 16'h0005); wr(3'd5, 16'h0008); wr(3'd2, 16'h0004);
    wr(3'd1, 16'h0008);
    tick(1); rd(3'd1, v); chk("R5 wrap at capture TOP", v, 16'h0000);
    chk("R7 output A set at BOTTOM", 16'(oc_out[0]), 16'h1);
    tick(4); chk("R5 output A high before match", 16'(oc_out[0]), 16'h1);
    tick(1); chk("R7 output A cleared by match", 16'(oc_out[0]), 16'h0);
    rd(3'd1, v); chk("R5 count after match", v, 16'h0005);
  endtask

  task automatic t_match_irq;
    logic [15:0] v;
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0005); wr(3'd1, 16'h0005);
    wr(3'd6, 16'h001F); wr(3'd7, 16'h0000);
    chk("R6 flags cleared", 16'(flags), 16'h0);
    tick(1);
    chk("R6 match B flag", 16'(flags[2]), 16'h1);
    chk("R7 normal toggle B", 16'(oc_out[1]), 16'h1);
    chk("R6 irq masked off", 16'(irq), 16'h0);
    wr(3'd7, 16'h0004); chk("R6 irq with mask", 16'(irq), 16'h1);
    wr(3'd6, 16'h0004); chk("R6 clear by one", 16'(flags[2]), 16'h0);
    chk("R6 irq drops", 16'(irq), 16'h0);
    wr(3'd7, 16'h0000);
  endtask

  task automatic t_force;
    logic [15:0] v;
    wr(3'd1, 16'h0100); wr(3'd6, 16'h001F);
    wr(3'd7, 16'h0400);
    chk("R8 force toggles C", 16'(oc_out[2]), 16'h1);
    chk("R8 force sets no flag", 16'(flags), 16'h0);
    rd(3'd1, v); chk("R8 count untouched", v, 16'h0100);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    wr(3'd0, 16'h0020); wr(3'd1, 16'h1234); wr(3'd6, 16'h001F);
    @(negedge clk); cap_pin = 1'b1; wait_clk(4);
    rd(3'd5, v); chk("R9 rising capture", v, 16'h1234);
    chk("R9 capture flag", 16'(flags[4]), 16'h1);
    wr(3'd1, 16'h2222);
    @(negedge clk); cap_pin = 1'b0; wait_clk(4);
    rd(3'd5, v); chk("R9 falling ignored", v, 16'h1234);
    wr(3'd0, 16'h0030); wr(3'd1, 16'h3030);
    @(negedge clk); cap_pin = 1'b1; wait_clk(3); cap_pin = 1'b0; wait_clk(3);
    rd(3'd5, v); chk("R9 other source ignored", v, 16'h1234);
    @(negedge clk); cmp_in = 1'b1; wait_clk(3); cmp_in = 1'b0; wait_clk(3);
    rd(3'd5, v); chk("R9 comparator capture", v, 16'h3030);
  endtask

  task automatic t_filter;
    logic [15:0] v;
    wr(3'd0, 16'h0070); wait_clk(6); wr(3'd1, 16'h3333);
    @(negedge clk); cmp_in = 1'b1; wait_clk(3); cmp_in = 1'b0; wait_clk(8);
    rd(3'd5, v); chk("R10 short pulse rejected", v, 16'h3030);
    wr(3'd1, 16'h4444);
    @(negedge clk); cmp_in = 1'b1; wait_clk(6); cmp_in = 1'b0; wait_clk(8);
    rd(3'd5, v); chk("R10 long pulse captured", v, 16'h4444);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(3); rst_n = 1'b1; wait_clk(1);
    t_reset; t_normal; t_fixed; t_topa; t_topcap;
    t_match_irq; t_force; t_capture; t_filter;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule